// File: doc/BRIEF.md
# Width-Switchable Integer Execution Stage

This block is the integer execution stage of a 64-bit core that can run code at either 64-bit or 32-bit effective register width. Each valid cycle it takes an operation code, two 64-bit sources (the second from a register or from the immediate), the current effective width and a per-instruction word override. It produces a 64-bit destination value that is registered one cycle later. When the operation width is 32, only the low word of each source counts. Each operation conditions its sources before the operation: it leaves them as they are, sign-extends them from bit 31, zero-extends them from bit 31, or truncates them. Every narrow result is then sign-extended from bit 31 to 64 bits.

In the same cycle the stage formats the next-PC value to the effective width. Under 32-bit width, bits above 31 are dropped and bit 31 fills the upper word. The word override changes only the operation width and never the PC width. A destination index of zero suppresses the write.

Top module: `xlen_exu`

## Requirements
- R1: With operation width 64, `op_i` selects: 0 add, 1 subtract, 2 signed set-less-than, 3 unsigned set-less-than, 4 shift left, 5 logical shift right, 6 arithmetic shift right, 7 rotate left, 8 rotate right, 9 and, 10 or, 11 xor. Any other code yields zero.
- R2: The operation width is 32 when `xlen32_i` or `word_i` is 1. At width 32, source bits 63:32 have no effect on the result.
- R3: At width 32, bits 63:32 of `result_o` equal bit 31, and bits 31:0 are the 32-bit result of the operation.
- R4: At width 32, set-less-than compares the low words (signed for code 2, unsigned for code 3). At every width the result is 1 or 0.
- R5: The shift and rotate amount is bits 4:0 of the second source at width 32 and bits 5:0 at width 64. At width 32, a logical right shift fills bit 31 downward with zeros, and an arithmetic right shift fills it with copies of source bit 31.
- R6: At width 32, rotates turn the low word within 32 bits.
- R7: With `xlen32_i`=0, `word_i`=1 makes the operation width 32 for that instruction only. The next instruction without the override runs at width 64.
- R8: `npc_o` is `npc_i` sign-extended from bit 31 when `xlen32_i`=1, and `npc_i` unchanged otherwise. `word_i` has no effect on `npc_o`.
- R9: When `rd_i` is 0, `we_o` is 0 and `result_o` is 0. Otherwise `we_o` equals `valid_o`.
- R10: `valid_o`, `rd_o`, `result_o` and `npc_o` follow a valid input one clock later. `valid_o` and `we_o` are 0 in a cycle that follows no valid input. All outputs are 0 during reset.
- R11: `use_imm_i`=1 takes the second source from `imm_i` instead of `rs2_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operation valid |
| op_i | input | 4 | Operation code |
| rs1_i | input | 64 | First source |
| rs2_i | input | 64 | Second register source |
| imm_i | input | 64 | Immediate |
| use_imm_i | input | 1 | Select immediate as second source |
| xlen32_i | input | 1 | Effective width is 32 |
| word_i | input | 1 | Word-form override, operation width 32 |
| rd_i | input | 5 | Destination index |
| npc_i | input | 64 | Next-PC value to format |
| valid_o | output | 1 | Result valid |
| we_o | output | 1 | Destination write enable |
| rd_o | output | 5 | Destination index |
| result_o | output | 64 | Destination value |
| npc_o | output | 64 | Formatted next PC |

## Verification
The operation result and the next-PC formatting are computed in the same cycle from separate width controls, so one instruction can narrow one of them and leave the other wide. The bench issues word-form operations at 64-bit effective width with a next-PC value that has its upper word set. It expects a sign-extended 32-bit result alongside an untouched 64-bit PC. It also runs the reverse case, a 32-bit effective width, where both must narrow together.

// File: rtl/xlen_exu_pkg.sv
package xlen_exu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_SLT  = 4'd2,
    OP_SLTU = 4'd3,
    OP_SLL  = 4'd4,
    OP_SRL  = 4'd5,
    OP_SRA  = 4'd6,
    OP_ROL  = 4'd7,
    OP_ROR  = 4'd8,
    OP_AND  = 4'd9,
    OP_OR   = 4'd10,
    OP_XOR  = 4'd11
  } exu_op_e;

  typedef enum logic [1:0] {
    EXT_RAW,
    EXT_SGN,
    EXT_ZRO
  } ext_e;
endpackage

// File: rtl/exu_src_prep.sv
module exu_src_prep
  import xlen_exu_pkg::*;
#(
  parameter int W  = 64,
  parameter int NW = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [3:0]     op_i,
  input  logic           narrow_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   a_o,
  output logic [W-1:0]   b_o,
  output logic [SHW-1:0] shamt_o
);
  localparam int NSHW = $clog2(NW);

  ext_e ext;

  always_comb begin
    unique case (op_i)
      OP_SLT, OP_SRA:                    ext = EXT_SGN;
      OP_SLTU, OP_SRL, OP_ROL, OP_ROR:   ext = EXT_ZRO;
      default:                           ext = EXT_RAW;
    endcase
    if (!narrow_i) ext = EXT_RAW;
  end

  function automatic logic [W-1:0] cond(input logic [W-1:0] v, input ext_e e);
    unique case (e)
      EXT_SGN: cond = {{(W-NW){v[NW-1]}}, v[NW-1:0]};
      EXT_ZRO: cond = {{(W-NW){1'b0}}, v[NW-1:0]};
      default: cond = v;
    endcase
  endfunction

  always_comb begin
    a_o = cond(a_i, ext);
    b_o = cond(b_i, ext);
    // narrow amount: upper shamt bit forced clear
    if (narrow_i) shamt_o = {{(SHW-NSHW){1'b0}}, b_i[NSHW-1:0]};
    else          shamt_o = b_i[SHW-1:0];
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import xlen_exu_pkg::*;
#(
  parameter int W  = 64,
  parameter int NW = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [3:0]     op_i,
  input  logic           narrow_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [SHW-1:0] shamt_i,
  output logic [W-1:0]   res_o
);
  logic [SHW:0]   inv_wide;
  logic [SHW:0]   inv_nar;
  logic [W-1:0]   rol_w, ror_w;
  logic [NW-1:0]  a_nar, rol_n, ror_n;

  assign a_nar    = a_i[NW-1:0];
  assign inv_wide = (SHW+1)'(W) - {1'b0, shamt_i};
  assign inv_nar  = (SHW+1)'(NW) - {1'b0, shamt_i};

  assign rol_w = (a_i << shamt_i) | (a_i >> inv_wide);
  assign ror_w = (a_i >> shamt_i) | (a_i << inv_wide);
  assign rol_n = (a_nar << shamt_i) | (a_nar >> inv_nar);
  assign ror_n = (a_nar >> shamt_i) | (a_nar << inv_nar);

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_SLT:  res_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      OP_SLTU: res_o = {{(W-1){1'b0}}, a_i < b_i};
      OP_SLL:  res_o = a_i << shamt_i;
      OP_SRL:  res_o = a_i >> shamt_i;
      OP_SRA:  res_o = W'($signed(a_i) >>> shamt_i);
      OP_ROL:  res_o = narrow_i ? {{(W-NW){1'b0}}, rol_n} : rol_w;
      OP_ROR:  res_o = narrow_i ? {{(W-NW){1'b0}}, ror_n} : ror_w;
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/exu_res_fmt.sv
module exu_res_fmt #(
  parameter int W  = 64,
  parameter int NW = 32
) (
  input  logic         narrow_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] val_o
);
  assign val_o = narrow_i ? {{(W-NW){val_i[NW-1]}}, val_i[NW-1:0]} : val_i;
endmodule

// File: rtl/xlen_exu.sv
module xlen_exu
  import xlen_exu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NLEN  = 32,
  parameter int RIDXW = 5,
  parameter int OPW   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OPW-1:0]   op_i,
  input  logic [XLEN-1:0]  rs1_i,
  input  logic [XLEN-1:0]  rs2_i,
  input  logic [XLEN-1:0]  imm_i,
  input  logic             use_imm_i,
  input  logic             xlen32_i,
  input  logic             word_i,
  input  logic [RIDXW-1:0] rd_i,
  input  logic [XLEN-1:0]  npc_i,
  output logic             valid_o,
  output logic             we_o,
  output logic [RIDXW-1:0] rd_o,
  output logic [XLEN-1:0]  result_o,
  output logic [XLEN-1:0]  npc_o
);
  localparam int SHW = $clog2(XLEN);

  logic             narrow;
  logic [XLEN-1:0]  src_b, a_c, b_c, alu_res, res_fmt, npc_fmt;
  logic [SHW-1:0]   shamt;
  logic             wr_ok;

  assign narrow = xlen32_i | word_i;
  assign src_b  = use_imm_i ? imm_i : rs2_i;
  assign wr_ok  = valid_i && (rd_i != '0);

  exu_src_prep #(.W(XLEN), .NW(NLEN)) u_prep (
    .op_i     (op_i),
    .narrow_i (narrow),
    .a_i      (rs1_i),
    .b_i      (src_b),
    .a_o      (a_c),
    .b_o      (b_c),
    .shamt_o  (shamt)
  );

  exu_alu #(.W(XLEN), .NW(NLEN)) u_alu (
    .op_i     (op_i),
    .narrow_i (narrow),
    .a_i      (a_c),
    .b_i      (b_c),
    .shamt_i  (shamt),
    .res_o    (alu_res)
  );

  exu_res_fmt #(.W(XLEN), .NW(NLEN)) u_res_fmt (
    .narrow_i (narrow),
    .val_i    (alu_res),
    .val_o    (res_fmt)
  );

  // PC follows effective width only, never the word override
  exu_res_fmt #(.W(XLEN), .NW(NLEN)) u_pc_fmt (
    .narrow_i (xlen32_i),
    .val_i    (npc_i),
    .val_o    (npc_fmt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      we_o     <= 1'b0;
      rd_o     <= '0;
      result_o <= '0;
      npc_o    <= '0;
    end else begin
      valid_o <= valid_i;
      we_o    <= wr_ok;
      if (valid_i) begin
        rd_o     <= rd_i;
        result_o <= wr_ok ? res_fmt : '0;
        npc_o    <= npc_fmt;
      end
    end
  end

  a_r3_narrow_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && narrow) |=> (result_o[XLEN-1:NLEN] == {(XLEN-NLEN){result_o[NLEN-1]}}));

  a_r4_cmp_bool: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_SLT || op_i == OP_SLTU)) |=> (result_o[XLEN-1:1] == '0));

  a_r8_pc_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && xlen32_i) |=> (npc_o[XLEN-1:NLEN] == {(XLEN-NLEN){npc_o[NLEN-1]}}));

  a_r8_pc_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !xlen32_i) |=> (npc_o == $past(npc_i)));

  a_r9_rd0_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rd_i == '0) |=> (!we_o && result_o == '0));

  a_r10_valid_lat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (valid_o == $past(valid_i)));

  a_r9_we_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> valid_o);
endmodule

// File: tb/xlen_exu_tb.sv
`timescale 1ns/1ps
module xlen_exu_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [63:0] rs1_i = '0, rs2_i = '0, imm_i = '0, npc_i = '0;
  logic        use_imm_i = 1'b0, xlen32_i = 1'b0, word_i = 1'b0;
  logic [4:0]  rd_i = '0;
  logic        valid_o, we_o;
  logic [4:0]  rd_o;
  logic [63:0] result_o, npc_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  xlen_exu u_dut (
    .clk_i, .rst_ni, .valid_i, .op_i, .rs1_i, .rs2_i, .imm_i, .use_imm_i,
    .xlen32_i, .word_i, .rd_i, .npc_i, .valid_o, .we_o, .rd_o, .result_o, .npc_o
  );

  function automatic logic [63:0] model(input int op, input logic [63:0] a,
                                        input logic [63:0] b, input bit nar);
    logic [31:0] a32, b32, r32;
    logic [63:0] r;
    int sh;
    a32 = a[31:0]; b32 = b[31:0];
    if (nar) begin
      sh = int'(b[4:0]);
      case (op)
        0: r32 = a32 + b32;
        1: r32 = a32 - b32;
        2: r32 = ($signed(a32) < $signed(b32)) ? 32'd1 : 32'd0;
        3: r32 = (a32 < b32) ? 32'd1 : 32'd0;
        4: r32 = a32 << sh;
        5: r32 = a32 >> sh;
        6: r32 = $signed(a32) >>> sh;
        7: begin r32 = a32; for (int i = 0; i < sh; i++) r32 = {r32[30:0], r32[31]}; end
        8: begin r32 = a32; for (int i = 0; i < sh; i++) r32 = {r32[0], r32[31:1]}; end
        9: r32 = a32 & b32;
        10: r32 = a32 | b32;
        11: r32 = a32 ^ b32;
        default: r32 = '0;
      endcase
      return {{32{r32[31]}}, r32};
    end
    sh = int'(b[5:0]);
    case (op)
      0: r = a + b;
      1: r = a - b;
      2: r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
      3: r = (a < b) ? 64'd1 : 64'd0;
      4: r = a << sh;
      5: r = a >> sh;
      6: r = $signed(a) >>> sh;
      7: begin r = a; for (int i = 0; i < sh; i++) r = {r[62:0], r[63]}; end
      8: begin r = a; for (int i = 0; i < sh; i++) r = {r[0], r[63:1]}; end
      9: r = a & b;
      10: r = a | b;
      11: r = a ^ b;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(input int op, input logic [63:0] a, input logic [63:0] b,
                       input bit x32, input bit w, input logic [4:0] rd,
                       input logic [63:0] pc, input bit imm);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = 4'(op); rs1_i = a;
    use_imm_i = imm;
    if (imm) begin imm_i = b; rs2_i = ~b; end else begin rs2_i = b; imm_i = ~b; end
    xlen32_i = x32; word_i = w; rd_i = rd; npc_i = pc;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic run(input string req, input int op, input logic [63:0] a,
                     input logic [63:0] b, input bit x32, input bit w);
    issue(op, a, b, x32, w, 5'd7, 64'h0, 1'b0);
    chk(req, result_o, model(op, a, b, x32 | w));
    chk({req, " we"}, {63'd0, we_o}, 64'd1);
  endtask

  task automatic t_reset();
    chk("R10 reset valid", {63'd0, valid_o}, 64'd0);
    chk("R10 reset result", result_o, 64'd0);
    chk("R10 reset npc", npc_o, 64'd0);
  endtask

  task automatic t_wide_ops();
    for (int op = 0; op < 13; op++)
      run("R1 wide op", op, 64'h8123_4567_89ab_cdef, 64'h0000_0000_0000_0025, 1'b0, 1'b0);
    run("R1 add carry", 0, 64'hffff_ffff_ffff_ffff, 64'd1, 1'b0, 1'b0);
  endtask

  task automatic t_narrow_ops();
    for (int op = 0; op < 12; op++)
      run("R3 narrow op", op, 64'h1234_5678_8000_00f1, 64'hdead_beef_0000_0013, 1'b1, 1'b0);
    // R2: junk upper words must not change result
    issue(0, 64'hffff_0000_7fff_ffff, 64'h0f0f_0f0f_0000_0001, 1'b1, 1'b0, 5'd3, 64'h0, 1'b0);
    chk("R2 upper ignored add", result_o, 64'hffff_ffff_8000_0000);
    issue(5, 64'haaaa_aaaa_8000_0000, 64'h0000_0000_0000_0004, 1'b1, 1'b0, 5'd3, 64'h0, 1'b0);
    chk("R2 upper ignored srl", result_o, 64'h0000_0000_0800_0000);
  endtask

  task automatic t_compare();
    run("R4 slt neg", 2, 64'h0000_0000_8000_0000, 64'hffff_ffff_0000_0001, 1'b1, 1'b0);
    chk("R4 slt neg val", result_o, 64'd1);
    run("R4 sltu", 3, 64'h0000_0000_8000_0000, 64'hffff_ffff_0000_0001, 1'b1, 1'b0);
    chk("R4 sltu val", result_o, 64'd0);
    run("R4 slt eq", 2, 64'h5555_0000_0000_0007, 64'h0000_0000_0000_0007, 1'b1, 1'b0);
    chk("R4 slt eq val", result_o, 64'd0);
  endtask

  task automatic t_shift();
    run("R5 sll amt mask", 4, 64'h0000_0000_0000_0003, 64'd33, 1'b1, 1'b0);
    chk("R5 sll 33 narrow", result_o, 64'd6);
    run("R5 sll wide 33", 4, 64'h0000_0000_0000_0003, 64'd33, 1'b0, 1'b0);
    chk("R5 sll 33 wide", result_o, 64'h0000_0006_0000_0000);
    run("R5 sra", 6, 64'h0000_0000_8000_0000, 64'd31, 1'b1, 1'b0);
    chk("R5 sra val", result_o, 64'hffff_ffff_ffff_ffff);
    run("R5 srl", 5, 64'hffff_ffff_8000_0000, 64'd31, 1'b1, 1'b0);
    chk("R5 srl val", result_o, 64'd1);
    run("R5 srl zero amt", 5, 64'h0000_0000_8000_0000, 64'd0, 1'b1, 1'b0);
    chk("R5 srl 0 val", result_o, 64'hffff_ffff_8000_0000);
  endtask

  task automatic t_rotate();
    run("R6 rol", 7, 64'hffff_ffff_8000_0001, 64'd1, 1'b1, 1'b0);
    chk("R6 rol val", result_o, 64'd3);
    run("R6 ror", 8, 64'h0000_0000_0000_0001, 64'd1, 1'b1, 1'b0);
    chk("R6 ror val", result_o, 64'hffff_ffff_8000_0000);
    run("R6 ror 0", 8, 64'h1234_5678_0000_0005, 64'd32, 1'b1, 1'b0);
    run("R1 rol wide", 7, 64'h8000_0000_0000_0001, 64'd4, 1'b0, 1'b0);
  endtask

  task automatic t_word();
    // R7: override then plain wide instruction
    issue(0, 64'h0000_0000_7fff_ffff, 64'd1, 1'b0, 1'b1, 5'd9, 64'hcafe_0000_1234_5678, 1'b0);
    chk("R7 addw", result_o, 64'hffff_ffff_8000_0000);
    chk("R8 word keeps pc wide", npc_o, 64'hcafe_0000_1234_5678);
    issue(0, 64'h0000_0000_7fff_ffff, 64'd1, 1'b0, 1'b0, 5'd9, 64'h0, 1'b0);
    chk("R7 next add wide", result_o, 64'h0000_0000_8000_0000);
    run("R7 sraw", 6, 64'h0000_0000_f000_0000, 64'd4, 1'b0, 1'b1);
  endtask

  task automatic t_pc();
    issue(0, 64'd1, 64'd1, 1'b1, 1'b0, 5'd2, 64'h1234_5678_9abc_def0, 1'b0);
    chk("R8 pc narrow neg", npc_o, 64'hffff_ffff_9abc_def0);
    chk("R3 paired result", result_o, 64'd2);
    issue(0, 64'd1, 64'd1, 1'b1, 1'b0, 5'd2, 64'hffff_0000_1000_0000, 1'b0);
    chk("R8 pc narrow pos", npc_o, 64'h0000_0000_1000_0000);
  endtask

  task automatic t_rd0();
    issue(0, 64'd5, 64'd6, 1'b0, 1'b0, 5'd0, 64'h0, 1'b0);
    chk("R9 rd0 we", {63'd0, we_o}, 64'd0);
    chk("R9 rd0 result", result_o, 64'd0);
    chk("R9 rd0 valid", {63'd0, valid_o}, 64'd1);
  endtask

  task automatic t_imm();
    issue(0, 64'd100, 64'hffff_ffff_ffff_fffe, 1'b0, 1'b0, 5'd4, 64'h0, 1'b1);
    chk("R11 imm add", result_o, 64'd98);
    chk("R10 rd out", {59'd0, rd_o}, 64'd4);
  endtask

  task automatic t_idle();
    @(negedge clk_i);
    chk("R10 idle valid", {63'd0, valid_o}, 64'd0);
    chk("R10 idle we", {63'd0, we_o}, 64'd0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_wide_ops();
    t_narrow_ops();
    t_compare();
    t_shift();
    t_rotate();
    t_word();
    t_pc();
    t_rd0();
    t_imm();
    t_idle();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule